// File: doc/BRIEF.md
# Double-Buffered List Select and Fault Status

This block holds the status byte of a sequencing converter controller. It records which of two command lists and which of two result lists the sequencer works from. In double-buffer mode it swaps each selection under its own rule. It latches a fatal flag when an uncorrectable (double-bit) memory error is reported, and it reports whether the controller is idle and ready for a restart. The sequencer, the converter and the protected memories sit outside the block. They report to it through single-cycle event strobes and level inputs.

The command-list select swaps when a restart arrives with load-ok set while the controller is idle. The result-list select swaps on a stored first result once the initial list has been filled, and on every abort. A latched memory fault freezes both swaps and raises a halt output. Only a soft reset or clearing the enable brings the block back into operation. Software sees one 8-bit register through a simple write-strobe/address bus with a combinational read path.

Top module: `dbl_list_status`

## Requirements
- R1: After the synchronous reset, the status register reads 0x08: the ready bit (bit 3) is 1 and every other bit is 0.
- R2: The status register sits at address 2. In it, bit 7 is the command-list select, bit 6 the result-list select, bit 5 the fault flag, bit 3 ready, and bits 4 and 2..0 always read 0. A read of any other address returns 0.
- R3: A write to address 2 loads bits 7 and 6 into the two selects only while `enable` is 0 or `priv_access` is 1, and otherwise changes nothing. The fault and ready bits never take write data.
- R4: With `cmd_dbl_mode` set, the command-list select inverts one cycle after a cycle in which `restart` and `load_ok` are both 1, ready reads 1 and no fault is latched. It does not invert without `load_ok` or while ready reads 0.
- R5: While a list's double-buffer mode input is 0, that list's select is forced to 0 from the next cycle on, and writes to it have no effect.
- R6: With `res_dbl_mode` set, the first `first_stored` strobe after reset or soft reset only marks the initial list as filled. Each later `first_stored` strobe inverts the result-list select.
- R7: Each `seq_abort` strobe inverts the result-list select. An abort and a `first_stored` strobe in the same cycle produce a single inversion.
- R8: An `ecc_dbl_err` strobe while `enable` is 1 sets the fault flag and `seq_halt` on the next cycle. While the fault is latched, neither select swaps and ready reads 0.
- R9: The fault flag clears one cycle after `enable` is 0 or `soft_rst` is 1. A soft reset also clears both selects and the initial-fill mark.
- R10: Ready reads 1 one cycle after a cycle in which `seq_idle` is 1 and `seq_abort` is 0, provided no fault is latched, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable |
| priv_access | input | 1 | Privileged access, unlocks select writes while enabled |
| cmd_dbl_mode | input | 1 | 1: command lists double-buffered |
| res_dbl_mode | input | 1 | 1: result lists double-buffered |
| load_ok | input | 1 | New command list loaded and valid |
| restart | input | 1 | Restart request strobe |
| soft_rst | input | 1 | Soft reset strobe |
| first_stored | input | 1 | Result of the first conversion of a list stored |
| seq_abort | input | 1 | Sequence abort strobe |
| ecc_dbl_err | input | 1 | Uncorrectable memory error strobe |
| seq_idle | input | 1 | Sequencer idle level |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| seq_halt | output | 1 | Fault latched, sequencing stopped |

## Verification
The hardest states to reach are the result-list swap rules that depend on history. The initial-fill mark is invisible at the ports. The stimulus therefore first issues a soft reset to put the mark in a known state. It then shows that one `first_stored` strobe leaves the select unchanged and the next one inverts it. The coincident abort and first-store cycle is driven only after the mark is known to be set, so that a double toggle would show as an unchanged select. The frozen swaps under a latched fault are forced the same way: a fault is latched first, and restart, store and abort strobes are then applied against known selects.

// File: rtl/dls_pkg.sv
// Package: shared field positions and the status byte layout for the
// list-select status block. Assumes an 8-bit register.
package dls_pkg;

    localparam int STS_W   = 8;
    localparam int CMD_POS = 7;
    localparam int RES_POS = 6;
    localparam int ERR_POS = 5;
    localparam int RDY_POS = 3;

    typedef struct packed {
        logic       cmd_sel;
        logic       res_sel;
        logic       fault;
        logic       rsvd;
        logic       ready;
        logic [2:0] pad;
    } sts_t;

    // Assemble a status byte with reserved and pad fields held at zero.
    function automatic sts_t make_sts(input logic c, input logic r,
                                      input logic f, input logic rd);
        sts_t s;
        s.cmd_sel = c;
        s.res_sel = r;
        s.fault   = f;
        s.rsvd    = 1'b0;
        s.ready   = rd;
        s.pad     = 3'b000;
        return s;
    endfunction

endpackage

// File: rtl/dls_bus_port.sv
// Module: register decode for the status byte. It qualifies select writes
// with the enable/privilege rule and muxes read data. Assumes a single
// register at STS_ADDR; every other address reads zero.
module dls_bus_port
    import dls_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int unsigned STS_ADDR = 2
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              enable,
    input  logic              priv_access,
    input  sts_t              sts,
    output logic              sel_wr,
    output logic [STS_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STS_ADDR);

    logic hit;

    // Decode address and write permission.
    always_comb begin
        hit    = (bus_addr == HIT_ADDR);
        sel_wr = bus_we && hit && (!enable || priv_access);
    end

    // Read mux with reserved bits forced to zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[CMD_POS] = sts.cmd_sel;
            rdata[RES_POS] = sts.res_sel;
            rdata[ERR_POS] = sts.fault;
            rdata[RDY_POS] = sts.ready;
        end
    end

endmodule

// File: rtl/dls_list_sel.sv
// Module: one list-select bit. Priority: single-buffer force, clear,
// software write, toggle. Assumes toggle is already qualified by the caller.
module dls_list_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl_mode,
    input  logic clr,
    input  logic wr_en,
    input  logic wr_val,
    input  logic toggle,
    output logic sel
);
    // Select register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sel <= 1'b0;
        else if (!dbl_mode || clr)  sel <= 1'b0;
        else if (wr_en)             sel <= wr_val;
        else if (toggle)            sel <= ~sel;
    end

endmodule

// File: rtl/dls_res_track.sv
// Module: decides when the result-list select swaps. It keeps the
// initial-fill mark. Assumes strobes are one cycle wide per event.
module dls_res_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic halted,
    input  logic first_stored,
    input  logic seq_abort,
    output logic toggle
);
    logic filled;

    // Initial-fill mark: set by the first stored first result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 filled <= 1'b0;
        else if (first_stored && !halted)  filled <= 1'b1;
    end

    // One toggle per cycle, however many events coincide.
    always_comb begin
        toggle = !halted && ((first_stored && filled) || seq_abort);
    end

endmodule

// File: rtl/dls_fault_ready.sv
// Module: latched uncorrectable-error flag and the ready indication.
// Assumes seq_idle is a level from the sequencer.
module dls_fault_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic soft_rst,
    input  logic ecc_dbl_err,
    input  logic seq_idle,
    input  logic seq_abort,
    output logic fault,
    output logic ready
);
    logic idle_q;

    // Fault latch: cleared by disable or soft reset, set by error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                   fault <= 1'b0;
        else if (!enable || soft_rst) fault <= 1'b0;
        else if (ecc_dbl_err)         fault <= 1'b1;
    end

    // Registered idle with no abort work pending.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b1;
        else        idle_q <= seq_idle && !seq_abort;
    end

    // Ready only when idle and not halted.
    always_comb ready = idle_q && !fault;

endmodule

// File: rtl/dbl_list_status.sv
// Module: top of the list-select status block. It ties the bus decode,
// the two list selects, the result swap tracker and the fault/ready logic.
// Assumes all event inputs are synchronous to clk.
module dbl_list_status
    import dls_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int unsigned STS_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              priv_access,
    input  logic              cmd_dbl_mode,
    input  logic              res_dbl_mode,
    input  logic              load_ok,
    input  logic              restart,
    input  logic              soft_rst,
    input  logic              first_stored,
    input  logic              seq_abort,
    input  logic              ecc_dbl_err,
    input  logic              seq_idle,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STS_W-1:0]  bus_wdata,
    output logic [STS_W-1:0]  bus_rdata,
    output logic              seq_halt
);
    logic sel_wr;
    logic cmd_sel;
    logic res_sel;
    logic fault;
    logic ready;
    logic cmd_toggle;
    logic res_toggle;
    sts_t sts;

    // Status byte assembly and command swap qualification.
    always_comb begin
        sts        = make_sts(cmd_sel, res_sel, fault, ready);
        cmd_toggle = restart && load_ok && ready && !fault;
        seq_halt   = fault;
    end

    dls_bus_port #(
        .ADDR_W   (ADDR_W),
        .STS_ADDR (STS_ADDR)
    ) u_bus (
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .enable      (enable),
        .priv_access (priv_access),
        .sts         (sts),
        .sel_wr      (sel_wr),
        .rdata       (bus_rdata)
    );

    dls_fault_ready u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .soft_rst    (soft_rst),
        .ecc_dbl_err (ecc_dbl_err),
        .seq_idle    (seq_idle),
        .seq_abort   (seq_abort),
        .fault       (fault),
        .ready       (ready)
    );

    dls_res_track u_rtrk (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (soft_rst),
        .halted       (fault),
        .first_stored (first_stored),
        .seq_abort    (seq_abort),
        .toggle       (res_toggle)
    );

    dls_list_sel u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbl_mode (cmd_dbl_mode),
        .clr      (soft_rst),
        .wr_en    (sel_wr),
        .wr_val   (bus_wdata[CMD_POS]),
        .toggle   (cmd_toggle),
        .sel      (cmd_sel)
    );

    dls_list_sel u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbl_mode (res_dbl_mode),
        .clr      (soft_rst),
        .wr_en    (sel_wr),
        .wr_val   (bus_wdata[RES_POS]),
        .toggle   (res_toggle),
        .sel      (res_sel)
    );

endmodule

// File: rtl/dls_status_chk.sv
// Module: assertion checker bound to dbl_list_status. It observes ports
// and the select/fault/ready state; it drives nothing.
module dls_status_chk #(
    parameter int          ADDR_W   = 4,
    parameter int unsigned STS_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              priv_access,
    input logic              cmd_dbl_mode,
    input logic              res_dbl_mode,
    input logic              load_ok,
    input logic              restart,
    input logic              soft_rst,
    input logic              seq_abort,
    input logic              ecc_dbl_err,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              seq_halt,
    input logic              cmd_sel,
    input logic              res_sel,
    input logic              fault,
    input logic              ready
);
    logic wr_ok;
    always_comb wr_ok = bus_we && (bus_addr == ADDR_W'(STS_ADDR)) &&
                        (!enable || priv_access);

    AST_CMD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dbl_mode && restart && load_ok && ready && !fault && !soft_rst && !wr_ok)
        |=> (cmd_sel != $past(cmd_sel))); // R4

    AST_SINGLE_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_dbl_mode |=> !cmd_sel); // R5

    AST_SINGLE_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_dbl_mode |=> !res_sel); // R5

    AST_ABORT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_dbl_mode && seq_abort && !fault && !soft_rst && !wr_ok)
        |=> (res_sel != $past(res_sel))); // R7

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ecc_dbl_err && !soft_rst) |=> seq_halt); // R8

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && cmd_dbl_mode && res_dbl_mode && !soft_rst && !wr_ok)
        |=> ($stable(cmd_sel) && $stable(res_sel))); // R8

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || soft_rst) |=> !seq_halt); // R9

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!cmd_sel && !res_sel)); // R9

endmodule

bind dbl_list_status dls_status_chk #(
    .ADDR_W   (ADDR_W),
    .STS_ADDR (STS_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .priv_access  (priv_access),
    .cmd_dbl_mode (cmd_dbl_mode),
    .res_dbl_mode (res_dbl_mode),
    .load_ok      (load_ok),
    .restart      (restart),
    .soft_rst     (soft_rst),
    .seq_abort    (seq_abort),
    .ecc_dbl_err  (ecc_dbl_err),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .seq_halt     (seq_halt),
    .cmd_sel      (cmd_sel),
    .res_sel      (res_sel),
    .fault        (fault),
    .ready        (ready)
);

// File: tb/dbl_list_status_bench.sv
`timescale 1ns/1ps
module dbl_list_status_bench;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b1;
    logic          priv_access = 1'b0;
    logic          cmd_dbl_mode = 1'b1;
    logic          res_dbl_mode = 1'b1;
    logic          load_ok = 1'b0;
    logic          restart = 1'b0;
    logic          soft_rst = 1'b0;
    logic          first_stored = 1'b0;
    logic          seq_abort = 1'b0;
    logic          ecc_dbl_err = 1'b0;
    logic          seq_idle = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = 4'd2;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          seq_halt;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dbl_list_status #(.ADDR_W(AW), .STS_ADDR(2)) u_dbl_list_status (
        .clk(clk), .rst_n(rst_n), .enable(enable), .priv_access(priv_access),
        .cmd_dbl_mode(cmd_dbl_mode), .res_dbl_mode(res_dbl_mode),
        .load_ok(load_ok), .restart(restart), .soft_rst(soft_rst),
        .first_stored(first_stored), .seq_abort(seq_abort),
        .ecc_dbl_err(ecc_dbl_err), .seq_idle(seq_idle), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_halt(seq_halt)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        chk("R1 status after reset", bus_rdata, 8'h08);
        chk("R1 halt after reset", {7'd0, seq_halt}, 8'h00);
    endtask

    task automatic t_layout();
        bus_addr = 4'd0; #1;
        chk("R2 other address reads 0", bus_rdata, 8'h00);
        bus_addr = 4'd2; #1;
        chk("R2 status address", bus_rdata, 8'h08);
    endtask

    task automatic t_write();
        wr(8'hFF);
        chk("R3 write locked while enabled", bus_rdata, 8'h08);
        enable = 1'b0; wr(8'hC0);
        chk("R3 write while disabled", bus_rdata, 8'hC8);
        enable = 1'b1; priv_access = 1'b1; wr(8'h40);
        chk("R3 privileged write", bus_rdata, 8'h48);
        wr(8'h20);
        chk("R3 fault/ready ignore write", bus_rdata, 8'h08);
        priv_access = 1'b0;
    endtask

    task automatic t_cmd_swap();
        seq_idle = 1'b0; step();
        chk("R10 busy clears ready", bus_rdata, 8'h00);
        restart = 1'b1; load_ok = 1'b1; step();
        chk("R4 no swap while busy", bus_rdata, 8'h00);
        restart = 1'b0; seq_idle = 1'b1; step();
        chk("R10 idle sets ready", bus_rdata, 8'h08);
        restart = 1'b1; load_ok = 1'b0; step();
        chk("R4 no swap without load_ok", bus_rdata, 8'h08);
        load_ok = 1'b1; step();
        restart = 1'b0; load_ok = 1'b0;
        chk("R4 swap on restart with load_ok", bus_rdata, 8'h88);
    endtask

    task automatic t_single();
        cmd_dbl_mode = 1'b0; step();
        chk("R5 command single forces 0", bus_rdata, 8'h08);
        priv_access = 1'b1; wr(8'hC0);
        chk("R5 write ignored in single mode", bus_rdata, 8'h48);
        res_dbl_mode = 1'b0; step();
        chk("R5 result single forces 0", bus_rdata, 8'h08);
        priv_access = 1'b0; cmd_dbl_mode = 1'b1; res_dbl_mode = 1'b1;
    endtask

    task automatic t_res_swap();
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        first_stored = 1'b1; step();
        chk("R6 initial fill no swap", bus_rdata, 8'h08);
        step();
        chk("R6 second store swaps", bus_rdata, 8'h48);
        step(); first_stored = 1'b0;
        chk("R6 third store swaps back", bus_rdata, 8'h08);
    endtask

    task automatic t_abort();
        seq_abort = 1'b1; step(); seq_abort = 1'b0;
        chk("R7 abort swaps, R10 ready low", bus_rdata, 8'h40);
        step();
        chk("R10 ready back after abort", bus_rdata, 8'h48);
        seq_abort = 1'b1; first_stored = 1'b1; step();
        seq_abort = 1'b0; first_stored = 1'b0;
        chk("R7 coincident events single swap", bus_rdata, 8'h00);
        step();
    endtask

    task automatic t_fault();
        ecc_dbl_err = 1'b1; step(); ecc_dbl_err = 1'b0;
        chk("R8 fault latched", bus_rdata, 8'h20);
        chk("R8 halt asserted", {7'd0, seq_halt}, 8'h01);
        restart = 1'b1; load_ok = 1'b1; step(); restart = 1'b0; load_ok = 1'b0;
        chk("R8 no command swap while halted", bus_rdata, 8'h20);
        first_stored = 1'b1; step(); first_stored = 1'b0;
        seq_abort = 1'b1; step(); seq_abort = 1'b0;
        chk("R8 no result swap while halted", bus_rdata, 8'h20);
        step();
    endtask

    task automatic t_recover();
        enable = 1'b0; step();
        chk("R9 disable clears fault", bus_rdata, 8'h08);
        chk("R9 halt released", {7'd0, seq_halt}, 8'h00);
        ecc_dbl_err = 1'b1; step();
        chk("R8 error ignored while disabled", bus_rdata, 8'h08);
        enable = 1'b1; step(); ecc_dbl_err = 1'b0;
        chk("R8 fault set again", bus_rdata, 8'h20);
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        chk("R9 soft reset clears fault", bus_rdata, 8'h08);
        enable = 1'b0; wr(8'hC0); enable = 1'b1;
        chk("R9 selects set before soft reset", bus_rdata, 8'hC8);
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        chk("R9 soft reset clears selects", bus_rdata, 8'h08);
        first_stored = 1'b1; step(); first_stored = 1'b0;
        chk("R9 fill mark cleared by soft reset", bus_rdata, 8'h08);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_layout();
        t_write();
        t_cmd_swap();
        t_single();
        t_res_swap();
        t_abort();
        t_fault();
        t_recover();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule